// File: doc/BRIEF.md
# Configurable Trigger Input Glitch Filter

This block cleans up an asynchronous trigger line before timer slave logic uses it. The raw line is first brought into the timer clock domain. It is then sampled at a rate chosen by a 4-bit filter code. A new level reaches the output only after that level has appeared on a run of consecutive samples. Together with the output level, the block gives a one-clock strobe for each rising change and each falling change of the filtered output.

The single filter code selects two things at once. The first is the sampling rate, which is either every timer clock or the reference clock enable divided by 2, 4, 8, 16 or 32. The second is the run length needed to accept a new level, which is 2, 4, 5, 6 or 8. Code 0 turns filtering off, and the synchronized input then drives the output directly. Changing the code discards any partly built run and restarts the rate divider.

Top module: `trig_glitch_filter`

## Requirements
- R1: The raw input passes through two synchronizer flops. With code 0 there is no filtering: a change on `trig_raw`, applied before edge E0, shows on `trig_filt` after the third rising clock edge (E2).
- R2: Codes 1, 2 and 3 sample on every clock and need 2, 4 and 8 consecutive samples of the new level. A clean change shows on the output after exactly N+2 edges.
- R3: Codes 4 and 5 sample every 2nd reference enable, codes 6 and 7 every 4th, and codes 8 and 9 every 8th. In each pair the even code needs 6 samples and the odd code needs 8.
- R4: Codes 10, 11 and 12 sample every 16th reference enable, and codes 13, 14 and 15 every 32nd. Within each group the codes need 5, 6 and 8 samples respectively. With sample period P clocks, a change appears between edge 3+(N-1)P and edge 2+NP.
- R5: The divided-rate codes advance only on cycles where `ref_ce` is 1. While `ref_ce` stays 0, the output holds its level whatever the input does.
- R6: A pulse on the input that is shorter than the required run never reaches the output.
- R7: A change of `filt_code` clears the run counter. After the change, a full run at the new setting is needed, counted from the cycle after the change.
- R8: After synchronous active-low reset, `trig_filt`, `rise_pulse` and `fall_pulse` are 0.
- R9: `rise_pulse` and `fall_pulse` go high for one clock, in the same cycle in which `trig_filt` takes its new value. The two are never high together.
- R10: The run counter always stays below the active threshold while filtering is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_ce | input | 1 | Reference clock enable, one cycle wide |
| trig_raw | input | 1 | Asynchronous trigger input |
| filt_code | input | 4 | Filter code that selects sample rate and run length |
| trig_filt | output | 1 | Filtered trigger level |
| rise_pulse | output | 1 | One-clock strobe on a 0-to-1 change of the output |
| fall_pulse | output | 1 | One-clock strobe on a 1-to-0 change of the output |

## Verification
The bench measures, for all sixteen codes, how many edges pass before the output follows an input change. It checks that count against the window allowed by the code's rate and run length. A decode that swapped a threshold or a divider would therefore land outside its window. The bench also applies a glitch one sample shorter than the run, which a design that counted too few samples would let through. It changes the code while a run is half built, and a counter that was not cleared would switch early. Finally it holds the reference enable low, and a divider that ignored the enable would keep sampling.

// File: rtl/tgf_pkg.sv
// Package: shared widths and the code decode for the trigger glitch filter.
// Assumes a 4-bit code; each code maps to a divider exponent and a run length.
package tgf_pkg;

    localparam int CODE_W = 4;
    localparam int THR_W  = 4;
    localparam int LOG_W  = 3;

    typedef struct packed {
        logic [LOG_W-1:0] div_log2;  // 0 = every clock, else ref enables / 2**n
        logic [THR_W-1:0] thr;       // consecutive samples needed, 0 = bypass
    } tgf_cfg_t;

    // Map a filter code to its rate and run length.
    function automatic tgf_cfg_t tgf_decode(input logic [CODE_W-1:0] code);
        tgf_cfg_t c;
        unique case (code)
            4'd0:    c = '{div_log2: 3'd0, thr: 4'd0};
            4'd1:    c = '{div_log2: 3'd0, thr: 4'd2};
            4'd2:    c = '{div_log2: 3'd0, thr: 4'd4};
            4'd3:    c = '{div_log2: 3'd0, thr: 4'd8};
            4'd4:    c = '{div_log2: 3'd1, thr: 4'd6};
            4'd5:    c = '{div_log2: 3'd1, thr: 4'd8};
            4'd6:    c = '{div_log2: 3'd2, thr: 4'd6};
            4'd7:    c = '{div_log2: 3'd2, thr: 4'd8};
            4'd8:    c = '{div_log2: 3'd3, thr: 4'd6};
            4'd9:    c = '{div_log2: 3'd3, thr: 4'd8};
            4'd10:   c = '{div_log2: 3'd4, thr: 4'd5};
            4'd11:   c = '{div_log2: 3'd4, thr: 4'd6};
            4'd12:   c = '{div_log2: 3'd4, thr: 4'd8};
            4'd13:   c = '{div_log2: 3'd5, thr: 4'd5};
            4'd14:   c = '{div_log2: 3'd5, thr: 4'd6};
            default: c = '{div_log2: 3'd5, thr: 4'd8};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tgf_sync.sv
// Module: tgf_sync
// Brings an asynchronous level into the clock domain through a flop chain.
// Assumes STAGES >= 2; output resets to 0.
module tgf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the synchronizer chain (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/tgf_sample_tick.sv
// Module: tgf_sample_tick
// Free-running divider that makes the sampling strobe. With div_log2 = 0 it
// strobes every clock; otherwise once per 2**div_log2 reference enables.
// Assumes restart is high in the cycle the divider setting changes.
module tgf_sample_tick #(
    parameter int LOG_W = 3,
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_ce,
    input  logic             restart,
    input  logic [LOG_W-1:0] div_log2,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             full_rate;

    // Terminal count of the divider for the current setting.
    always_comb begin
        lim       = DIV_W'((32'd1 << div_log2) - 32'd1);
        full_rate = (div_log2 == '0);
    end

    // Strobe at the wrap of the divider, never in a restart cycle (R5, R7).
    always_comb begin
        if (restart)        tick = 1'b0;
        else if (full_rate) tick = 1'b1;
        else                tick = ref_ce && (cnt == lim);
    end

    // Count reference enables, wrapping at the terminal count (R5).
    always_ff @(posedge clk) begin
        if (!rst_n || restart)           cnt <= '0;
        else if (ref_ce && !full_rate)   cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end

    // R5: the divider never leaves its range for the active setting.
    p_div_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt <= lim));
    // R5: without a reference enable the divider does not move.
    p_div_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_ce && !restart) |=> $stable(cnt));
endmodule

// File: rtl/tgf_level_core.sv
// Module: tgf_level_core
// Run-length filter. On each strobe it compares the sample with the output
// level and with the previous sample, and it changes the output once a run
// reaches thr. Bypass copies the input straight through.
// Assumes thr >= 2 whenever bypass is low.
module tgf_level_core #(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             clear,
    input  logic             tick,
    input  logic             samp_in,
    input  logic [THR_W-1:0] thr,
    output logic             level,
    output logic             rise,
    output logic             fall
);
    logic [THR_W-1:0] run_cnt, run_nxt;
    logic             prev, prev_nxt;
    logic             lvl_nxt;
    logic [THR_W:0]   run_inc;

    // Next run count, previous sample and output level.
    always_comb begin
        run_nxt  = run_cnt;
        prev_nxt = prev;
        lvl_nxt  = level;
        run_inc  = {1'b0, run_cnt} + 1'b1;
        if (bypass) begin
            lvl_nxt  = samp_in;
            prev_nxt = samp_in;
            run_nxt  = '0;
        end else if (clear) begin
            run_nxt  = '0;
        end else if (tick) begin
            prev_nxt = samp_in;
            if (samp_in == level) begin
                run_nxt = '0;
            end else if (samp_in == prev) begin
                if (run_inc >= {1'b0, thr}) begin
                    lvl_nxt = samp_in;
                    run_nxt = '0;
                end else begin
                    run_nxt = run_inc[THR_W-1:0];
                end
            end else begin
                run_nxt = THR_W'(1);
            end
        end
    end

    // Register the state and the change strobes (R8, R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            prev    <= 1'b0;
            level   <= 1'b0;
            rise    <= 1'b0;
            fall    <= 1'b0;
        end else begin
            run_cnt <= run_nxt;
            prev    <= prev_nxt;
            level   <= lvl_nxt;
            rise    <= lvl_nxt & ~level;
            fall    <= ~lvl_nxt & level;
        end
    end

    // R10: the run stays below the threshold while filtering.
    p_run_below_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !clear) |-> (run_cnt < thr));
    // R5: the level only moves on a sampling strobe when filtering.
    p_hold_without_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bypass) |=> $stable(level));
endmodule

// File: rtl/trig_glitch_filter.sv
// Module: trig_glitch_filter (top)
// Synchronizes a trigger input, decodes the filter code, and ties the
// sample divider to the run-length core. A code change restarts the divider
// and clears the run. Assumes ref_ce is one clock wide.
module trig_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ref_ce,
    input  logic                      trig_raw,
    input  logic [tgf_pkg::CODE_W-1:0] filt_code,
    output logic                      trig_filt,
    output logic                      rise_pulse,
    output logic                      fall_pulse
);
    import tgf_pkg::*;

    logic [CODE_W-1:0] code_q;
    logic              code_chg;
    logic              sync_lvl;
    logic              tick;
    tgf_cfg_t          cfg;

    // Hold the last code so a change can be seen (R7).
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= filt_code;
    end

    // Decode rate and run length, and flag a code change.
    always_comb begin
        cfg      = tgf_decode(filt_code);
        code_chg = (filt_code != code_q);
    end

    tgf_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (trig_raw),
        .q_sync  (sync_lvl)
    );

    tgf_sample_tick #(.LOG_W(LOG_W), .DIV_W(DIV_W)) i_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_ce   (ref_ce),
        .restart  (code_chg),
        .div_log2 (cfg.div_log2),
        .tick     (tick)
    );

    tgf_level_core #(.THR_W(THR_W)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .bypass  (cfg.thr == '0),
        .clear   (code_chg),
        .tick    (tick),
        .samp_in (sync_lvl),
        .thr     (cfg.thr),
        .level   (trig_filt),
        .rise    (rise_pulse),
        .fall    (fall_pulse)
    );

    // R9: the two strobes are never high together.
    p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_pulse && fall_pulse));
    // R9: every rise of the output carries a rising strobe.
    p_rise_marked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_filt) |-> rise_pulse);
    // R9: every fall of the output carries a falling strobe.
    p_fall_marked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_filt) |-> fall_pulse);
endmodule

// File: tb/test_trig_glitch_filter.sv
module test_trig_glitch_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_ce = 1'b1;
    logic       trig_raw = 1'b0;
    logic [3:0] filt_code = 4'd0;
    logic       trig_filt, rise_pulse, fall_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    trig_glitch_filter i_trig_glitch_filter (
        .clk(clk), .rst_n(rst_n), .ref_ce(ref_ce), .trig_raw(trig_raw),
        .filt_code(filt_code), .trig_filt(trig_filt),
        .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
    );

    // {code, run length N, sample period P in clocks with ref_ce held high}
    localparam int VEC [16][3] = '{
        '{0, 0, 1},  '{1, 2, 1},  '{2, 4, 1},  '{3, 8, 1},
        '{4, 6, 2},  '{5, 8, 2},  '{6, 6, 4},  '{7, 8, 4},
        '{8, 6, 8},  '{9, 8, 8},  '{10, 5, 16}, '{11, 6, 16},
        '{12, 8, 16}, '{13, 5, 32}, '{14, 6, 32}, '{15, 8, 32}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        int lo, hi, k;
        bit target;
        bit seen;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(trig_filt == 1'b0, "R8 out", int'(trig_filt), 0);
        chk(rise_pulse == 1'b0 && fall_pulse == 1'b0, "R8 strobes",
            int'(rise_pulse) + int'(fall_pulse), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: latency window per code (R1..R4) and strobes (R9).
        foreach (VEC[i]) begin
            filt_code = 4'(VEC[i][0]);
            repeat (VEC[i][2] * 2 + 4) @(negedge clk);
            target = ~trig_filt;
            trig_raw = target;
            if (VEC[i][1] == 0) begin lo = 3; hi = 3; end
            else begin
                lo = 3 + (VEC[i][1] - 1) * VEC[i][2];
                hi = 2 + VEC[i][1] * VEC[i][2];
            end
            k = 0;
            seen = 1'b0;
            while (!seen && k < 400) begin
                @(negedge clk);
                k++;
                if (trig_filt == target) seen = 1'b1;
            end
            if (VEC[i][0] == 0)
                chk(k == 3, "R1 bypass latency", k, 3);
            else if (VEC[i][0] <= 3)
                chk(k == lo, "R2 timer-rate latency", k, lo);
            else if (VEC[i][0] <= 9)
                chk(k >= lo && k <= hi, "R3 divided latency", k, lo);
            else
                chk(k >= lo && k <= hi, "R4 divided latency", k, lo);
            chk(target ? rise_pulse : fall_pulse, "R9 strobe with change", 0, 1);
            @(negedge clk);
            chk(!rise_pulse && !fall_pulse, "R9 strobe one cycle",
                int'(rise_pulse) + int'(fall_pulse), 0);
        end

        // Bring output to 0 using bypass.
        filt_code = 4'd0;
        trig_raw = 1'b0;
        repeat (5) @(negedge clk);
        chk(trig_filt == 1'b0, "R1 bypass low", int'(trig_filt), 0);

        // R6: glitch of 7 clocks with run length 8 is rejected.
        filt_code = 4'd3;
        repeat (4) @(negedge clk);
        trig_raw = 1'b1;
        repeat (7) @(negedge clk);
        trig_raw = 1'b0;
        repeat (20) @(negedge clk);
        chk(trig_filt == 1'b0, "R6 short glitch", int'(trig_filt), 0);

        // R7: half-built run is cleared on a code change.
        trig_raw = 1'b1;
        repeat (6) @(negedge clk);
        filt_code = 4'd2;
        repeat (4) @(negedge clk);
        chk(trig_filt == 1'b0, "R7 no early switch", int'(trig_filt), 0);
        @(negedge clk);
        chk(trig_filt == 1'b1, "R7 full run after change", int'(trig_filt), 1);

        // R5: no reference enable, no sampling on a divided code.
        filt_code = 4'd4;
        repeat (6) @(negedge clk);
        ref_ce = 1'b0;
        trig_raw = 1'b0;
        repeat (60) @(negedge clk);
        chk(trig_filt == 1'b1, "R5 hold without ref_ce", int'(trig_filt), 1);
        ref_ce = 1'b1;
        repeat (20) @(negedge clk);
        chk(trig_filt == 1'b0, "R5 resumes with ref_ce", int'(trig_filt), 0);

        // R8: reset mid-run returns outputs to 0.
        filt_code = 4'd0;
        trig_raw = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(trig_filt == 1'b0 && !rise_pulse && !fall_pulse, "R8 reset again",
            int'(trig_filt), 0);

        done = 1'b1;
        finish_run();
    end
endmodule